// File: doc/BRIEF.md
# Oscillator Stabilization and Watchdog Prescale Counter

This block times how long the crystal oscillator must run before the bus clock may be enabled. The crystal oscillator starts at power-on and restarts when the device leaves stop mode. The timer is a twelve-stage ripple-style counter clocked on the falling edge of the crystal clock. A thirteenth stage is set when the twelve stages roll over. That stage returns the chain to zero and supplies a one-cycle tick to the watchdog, so the same counter also serves as the watchdog prescaler.

After a power-on reset pulse, the bus clock enable stays low until a full 4096-edge interval has run. A stop strobe clears the counter and drops the bus clock enable. The counter then holds at zero until a wake event arrives. On the wake event the short-recovery option is captured. The captured value selects a 32-edge or a 4096-edge recovery interval. When the interval ends, a one-cycle done pulse is issued together with the rising bus clock enable. The external reset pin does not touch the counter.

All inputs other than the power-on pulse are synchronous to the falling edge of the crystal clock. The power-on pulse is asynchronous and active high. There is no data stream, so every pin is a plain control or status signal.

Top module: `osc_stab_timer`

## Requirements
- R1: While the power-on pulse is high, bus_clk_en_o, recov_done_o and wdog_tick_o are all 0.
- R2: After the power-on pulse falls, bus_clk_en_o rises on the 4096th falling edge of the crystal clock. It then stays high until a stop strobe is accepted.
- R3: recov_done_o is high for exactly one crystal cycle, and only on the edge where bus_clk_en_o rises. This applies both after power-on and after stop recovery.
- R4: A stop strobe sampled while the bus clock is enabled drives bus_clk_en_o low on that same edge. It clears the counter to zero and holds it there, and no watchdog tick occurs until a wake event.
- R5: With the short-recovery option at 1 on the wake edge, bus_clk_en_o rises on the 32nd falling edge after the wake edge.
- R6: With the short-recovery option at 0 on the wake edge, bus_clk_en_o rises on the 4096th falling edge after the wake edge.
- R7: The short-recovery option is captured on the wake edge. Later changes to it during the recovery interval have no effect.
- R8: wdog_tick_o pulses for one cycle every 4096 falling edges. After a stop and wake, the first tick comes 4096 edges after the wake edge, because counting restarts from zero.
- R9: Asserting the external reset pin (ext_rst_n_i low) has no effect on the counter, the tick period or bus_clk_en_o.
- R10: A wake event while the bus clock is already enabled is ignored: no done pulse occurs and bus_clk_en_o stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| xtal_clk_i | input | 1 | Crystal clock; the logic acts on its falling edge |
| por_i | input | 1 | Power-on reset pulse, asynchronous, active high |
| stop_i | input | 1 | Stop-entry strobe |
| wake_i | input | 1 | Wake event (interrupt, break or reset) |
| short_rec_i | input | 1 | Short-recovery option: 1 selects 32 edges, 0 selects 4096 |
| ext_rst_n_i | input | 1 | External reset pin, active low; does not affect the counter |
| bus_clk_en_o | output | 1 | Bus clock enable |
| recov_done_o | output | 1 | One-cycle pulse when a stabilization interval ends |
| wdog_tick_o | output | 1 | Watchdog clock tap from the thirteenth stage |

## Verification
A counter that is not cleared on stop shows up at the ports as a first watchdog tick that does not come 4096 edges after the wake. It also shows up as a short recovery that ends early or late, and either symptom is visible within one recovery interval. A wrong tap, or a live rather than captured option bit, moves the bus clock enable edge away from edge 32 or edge 4096. A state machine stuck outside its run state shows up as a bus clock enable that never rises or a done pulse that never comes, and the bench catches this within one interval through its bounded waits.

// File: rtl/osc_stab_pkg.sv
package osc_stab_pkg;
  typedef enum logic [1:0] {
    ST_PORWAIT = 2'd0,
    ST_RUN     = 2'd1,
    ST_STOPPED = 2'd2,
    ST_RECOVER = 2'd3
  } stab_state_e;
endpackage

// File: rtl/osc_stab_chain.sv
module osc_stab_chain #(
  parameter int STAGES    = 12,
  parameter int SHORT_TAP = 5
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              zero_i,
  output logic [STAGES-1:0] cnt_o,
  output logic              short_hit_o,
  output logic              long_hit_o,
  output logic              tick_o
);
  logic [STAGES-1:0] cnt_q;
  logic [STAGES:0]   en;
  logic              tick_q;

  // ripple-style toggle enables: stage i toggles when all lower stages are 1
  assign en[0] = 1'b1;
  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    assign en[i+1] = en[i] & cnt_q[i];
    always_ff @(negedge clk_i or posedge rst_i) begin
      if (rst_i)                  cnt_q[i] <= 1'b0;
      else if (zero_i || en[STAGES]) cnt_q[i] <= 1'b0;
      else if (en[i])             cnt_q[i] <= ~cnt_q[i];
    end
  end

  // thirteenth stage: set on rollover, restarts the chain and clocks the watchdog
  always_ff @(negedge clk_i or posedge rst_i) begin
    if (rst_i) tick_q <= 1'b0;
    else       tick_q <= en[STAGES] & ~zero_i;
  end

  assign cnt_o       = cnt_q;
  assign short_hit_o = en[SHORT_TAP];
  assign long_hit_o  = en[STAGES];
  assign tick_o      = tick_q;

  AST_TICK_AFTER_FULL: assert property (@(negedge clk_i) disable iff (rst_i)
    tick_q |-> (cnt_q == '0) && ($past(cnt_q) == {STAGES{1'b1}})); // R8
  AST_TICK_ONE_CYCLE: assert property (@(negedge clk_i) disable iff (rst_i)
    tick_q |=> !tick_q); // R8
endmodule

// File: rtl/osc_stab_ctrl.sv
module osc_stab_ctrl
  import osc_stab_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_i,
  input  logic        stop_i,
  input  logic        wake_i,
  input  logic        short_opt_i,
  input  logic        short_hit_i,
  input  logic        long_hit_i,
  output logic        zero_o,
  output logic        bus_en_o,
  output logic        done_o,
  output stab_state_e state_o
);
  stab_state_e st_q, st_d;
  logic short_q, bus_en_q, done_q, fin;

  assign fin = short_q ? short_hit_i : long_hit_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_PORWAIT: if (long_hit_i) st_d = ST_RUN;
      ST_RUN:     if (stop_i)     st_d = ST_STOPPED;
      ST_STOPPED: if (wake_i)     st_d = ST_RECOVER;
      ST_RECOVER: if (fin)        st_d = ST_RUN;
      default:                    st_d = ST_PORWAIT;
    endcase
  end

  assign zero_o = (st_q == ST_STOPPED) || ((st_q == ST_RUN) && stop_i);

  always_ff @(negedge clk_i or posedge rst_i) begin
    if (rst_i) begin
      st_q     <= ST_PORWAIT;
      short_q  <= 1'b0;
      bus_en_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      st_q     <= st_d;
      if (st_q == ST_STOPPED && wake_i) short_q <= short_opt_i;
      bus_en_q <= (st_d == ST_RUN);
      done_q   <= (st_q != ST_RUN) && (st_d == ST_RUN);
    end
  end

  assign bus_en_o = bus_en_q;
  assign done_o   = done_q;
  assign state_o  = st_q;

  AST_DONE_ONE_CYCLE: assert property (@(negedge clk_i) disable iff (rst_i)
    done_q |=> !done_q); // R3
  AST_EN_RISE_WITH_DONE: assert property (@(negedge clk_i) disable iff (rst_i)
    $rose(bus_en_q) |-> done_q); // R3
  AST_STOP_DROPS_EN: assert property (@(negedge clk_i) disable iff (rst_i)
    (st_q == ST_RUN && stop_i) |=> !bus_en_q); // R4
  AST_OPT_HELD: assert property (@(negedge clk_i) disable iff (rst_i)
    (st_q == ST_RECOVER && $past(st_q) == ST_RECOVER) |-> $stable(short_q)); // R7
  AST_WAKE_IN_RUN: assert property (@(negedge clk_i) disable iff (rst_i)
    (st_q == ST_RUN && !stop_i && wake_i) |=> (bus_en_q && !done_q)); // R10
endmodule

// File: rtl/osc_stab_timer.sv
module osc_stab_timer
  import osc_stab_pkg::*;
#(
  parameter int STAGES    = 12,
  parameter int SHORT_TAP = 5
) (
  input  logic xtal_clk_i,
  input  logic por_i,
  input  logic stop_i,
  input  logic wake_i,
  input  logic short_rec_i,
  input  logic ext_rst_n_i,
  output logic bus_clk_en_o,
  output logic recov_done_o,
  output logic wdog_tick_o
);
  logic [STAGES-1:0] cnt;
  logic zero, short_hit, long_hit;
  stab_state_e state;

  osc_stab_chain #(.STAGES(STAGES), .SHORT_TAP(SHORT_TAP)) u_chain (
    .clk_i       (xtal_clk_i),
    .rst_i       (por_i),
    .zero_i      (zero),
    .cnt_o       (cnt),
    .short_hit_o (short_hit),
    .long_hit_o  (long_hit),
    .tick_o      (wdog_tick_o)
  );

  osc_stab_ctrl u_ctrl (
    .clk_i       (xtal_clk_i),
    .rst_i       (por_i),
    .stop_i      (stop_i),
    .wake_i      (wake_i),
    .short_opt_i (short_rec_i),
    .short_hit_i (short_hit),
    .long_hit_i  (long_hit),
    .zero_o      (zero),
    .bus_en_o    (bus_clk_en_o),
    .done_o      (recov_done_o),
    .state_o     (state)
  );

  AST_STOP_CLEARS: assert property (@(negedge xtal_clk_i) disable iff (por_i)
    (state == ST_RUN && stop_i) |=> (cnt == '0)); // R4
  AST_STOPPED_HOLDS: assert property (@(negedge xtal_clk_i) disable iff (por_i)
    (state == ST_STOPPED) |-> (cnt == '0 && !wdog_tick_o)); // R4
  AST_EXT_RST_NO_EFFECT: assert property (@(negedge xtal_clk_i) disable iff (por_i)
    (!ext_rst_n_i && !zero && !long_hit) |=> (cnt == $past(cnt) + 1'b1)); // R9
endmodule

// File: tb/osc_stab_timer_tb_top.sv
`timescale 1ns/1ps
module osc_stab_timer_tb_top;
  logic clk = 1'b0;
  logic por = 1'b1, stop = 1'b0, wake = 1'b0, short_rec = 1'b0, ext_rst_n = 1'b1;
  logic bus_en, done, tick;
  int checks = 0, errors = 0;
  int cyc = 0;

  always #2 clk = ~clk; // 250 MHz

  osc_stab_timer dut_i (
    .xtal_clk_i (clk), .por_i (por), .stop_i (stop), .wake_i (wake),
    .short_rec_i (short_rec), .ext_rst_n_i (ext_rst_n),
    .bus_clk_en_o (bus_en), .recov_done_o (done), .wdog_tick_o (tick)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 200000);
      summary();
    end
  end

  // one falling edge, then sample just after it
  task automatic step();
    @(negedge clk); #1;
  endtask

  // count edges until bus_en is high; returns edge count, seen done pulses
  task automatic edges_to_en(output int n, output int dones, output int done_at);
    n = 0; dones = 0; done_at = -1;
    while (!bus_en && n < 10000) begin
      step(); n++;
      if (done) begin dones++; done_at = n; end
    end
    step();
    if (done) dones++;
  endtask

  task automatic t_reset();
    repeat (5) @(posedge clk);
    chk(bus_en == 0, "R1 bus_en", bus_en, 0);
    chk(done == 0, "R1 done", done, 0);
    chk(tick == 0, "R1 tick", tick, 0);
  endtask

  task automatic t_por();
    int n, d, at;
    @(posedge clk); por = 1'b0;
    edges_to_en(n, d, at);
    chk(n == 4096, "R2 por interval", n, 4096);
    chk(d == 1, "R3 single done after por", d, 1);
    chk(at == n, "R3 done with enable", at, n);
    repeat (20) step();
    chk(bus_en == 1, "R2 enable stays", bus_en, 1);
  endtask

  task automatic do_stop();
    @(posedge clk); stop = 1'b1;
    step();
    @(posedge clk); stop = 1'b0;
    chk(bus_en == 0, "R4 stop drops enable", bus_en, 0);
  endtask

  task automatic t_stop_short();
    int n, d, at, ticks;
    do_stop();
    ticks = 0;
    for (int i = 0; i < 5000; i++) begin step(); if (tick) ticks++; end
    chk(ticks == 0, "R4 no tick while stopped", ticks, 0);
    chk(bus_en == 0, "R4 stays disabled", bus_en, 0);
    @(posedge clk); wake = 1'b1; short_rec = 1'b1;
    step();
    @(posedge clk); wake = 1'b0; short_rec = 1'b0; // R7: later change ignored
    edges_to_en(n, d, at);
    chk(n == 32, "R5 R7 short interval", n, 32);
    chk(d == 1, "R3 single done after short", d, 1);
    // R8: first tick 4096 edges after wake edge; n+1 edges already elapsed
    n = n + 1;
    while (!tick && n < 10000) begin step(); n++; end
    chk(n == 4096, "R8 first tick after wake", n, 4096);
  endtask

  task automatic t_stop_long();
    int n, d, at;
    do_stop();
    repeat (10) step();
    @(posedge clk); wake = 1'b1; short_rec = 1'b0;
    step();
    @(posedge clk); wake = 1'b0; short_rec = 1'b1;
    edges_to_en(n, d, at);
    chk(n == 4096, "R6 R7 long interval", n, 4096);
    chk(d == 1, "R3 single done after long", d, 1);
  endtask

  task automatic t_tick_ext_rst();
    int n, lows;
    n = 0;
    while (!tick && n < 10000) begin step(); n++; end
    n = 0; lows = 0;
    @(posedge clk); ext_rst_n = 1'b0;
    do begin
      step(); n++;
      if (n == 300) begin @(posedge clk); ext_rst_n = 1'b1; end
      if (!bus_en) lows++;
    end while (!tick && n < 10000);
    chk(n == 4096, "R8 R9 tick period with ext reset", n, 4096);
    chk(lows == 0, "R9 enable unaffected", lows, 0);
  endtask

  task automatic t_wake_in_run();
    int dones, lows;
    dones = 0; lows = 0;
    @(posedge clk); wake = 1'b1; short_rec = 1'b1;
    for (int i = 0; i < 40; i++) begin
      step();
      if (done) dones++;
      if (!bus_en) lows++;
    end
    @(posedge clk); wake = 1'b0;
    chk(dones == 0, "R10 no done on wake in run", dones, 0);
    chk(lows == 0, "R10 enable stays", lows, 0);
  endtask

  initial begin
    t_reset();
    t_por();
    t_stop_short();
    t_stop_long();
    t_tick_ext_rst();
    t_wake_in_run();
    summary();
  end
endmodule